// File: doc/BRIEF.md
# Sixteen-Bit Timer with Compare-Driven Period Reset

This block is a 16-bit up-counter that software sets up and reads through a byte-wide register bus. It counts either every clock or rising edges of an external count input. The external input can pass through a two-flop synchronizer or be taken directly. A 1/2/4/8 prescaler sits in front of the counter. When the counter wraps from its maximum back to zero, a sticky overflow flag is set. The interrupt line reports that flag when its enable bit is set.

A compare unit holds a 16-bit compare value and a 4-bit mode field. In the special-trigger mode, a count tick taken while the counter equals the compare value sends the counter back to zero instead of advancing it. This turns the compare value into a period register. The same event drives a one-cycle pulse that starts an analog-to-digital conversion. This reset never sets the overflow flag. A bus write to the counter in the same cycle cancels it.

Bus map (3-bit address): 0 control, 1 counter low byte, 2 counter high byte, 3 compare low byte, 4 compare high byte, 5 compare mode, 6 overflow flag, 7 interrupt enable. Reads are combinational. Writes take effect at the clock edge that samples `bus_we`.

Top module: `cmp_timer16`

## Requirements
- R1: Each count tick adds one to the counter, and a tick at 0xFFFF yields 0x0000.
- R2: Control bits 5:4 pick the prescale. Codes 00, 01, 10 and 11 produce one tick per 1, 2, 4 and 8 count events. A bus write to address 1 or 2 clears the prescaler, and any count event in that cycle is dropped.
- R3: A tick that wraps the counter sets the flag, which is bit 0 at address 6. The flag stays set until software writes 0 to that bit. A write of 1 sets it.
- R4: `irq` is high exactly when the flag and the enable bit (bit 0 at address 7) are both 1.
- R5: The special event occurs when the mode at address 5 (bits 3:0) equals 4'b1011 and a tick arrives while the counter equals the compare pair (addresses 3 and 4). The counter then becomes 0x0000, and `adc_start` is high for the following cycle.
- R6: A special event never sets the flag, even when the compare value is 0xFFFF.
- R7: A write to address 1 or 2 in the cycle of a would-be special event keeps the written byte. The reset and the `adc_start` pulse are both cancelled.
- R8: With control bit 1 set, count events are rising edges of `ext_in`. Control bit 2 clear sends the input through a two-flop synchronizer. Control bit 2 set takes it directly.
- R9: Reset sets control, compare, mode, flag and enable to zero, and leaves the counter unchanged. Control bits 7:6 always read 0.
- R10: When external counting uses the direct input (control bits 2 and 1 both set), no special event occurs.
- R11: With control bit 0 clear, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ext_in | input | 1 | External count input |
| irq | output | 1 | Overflow interrupt request |
| adc_start | output | 1 | One-cycle conversion-start pulse |

## Verification
Register reads settle within the same cycle, so the bench samples them 1 ns after the falling edge that set the address. An internal count tick moves the counter at the rising edge that follows the write enabling the run bit. Every run therefore spans a known number of edges, and the expected count is computed as events shifted by the prescale, taken modulo the period where a compare reset applies. The synchronized external path adds two cycles before the counter moves, and the direct path adds none. The bench waits six idle cycles after the last pulse before it reads. `adc_start` is counted at falling edges, and the bench waits two cycles after a run stops before it compares that count.

// File: rtl/ctim_pkg.sv
package ctim_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 3;
    localparam int MODE_W = 4;
    localparam int PS_SEL_W = 2;

    localparam logic [MODE_W-1:0] MODE_SPECIAL = 4'b1011;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_CNT_LO = 3'd1,
        A_CNT_HI = 3'd2,
        A_CMP_LO = 3'd3,
        A_CMP_HI = 3'd4,
        A_MODE   = 3'd5,
        A_FLAG   = 3'd6,
        A_IE     = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [PS_SEL_W-1:0] prescale;
        logic                osc_en;
        logic                async_ext;
        logic                ext_src;
        logic                run;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_byte(input logic [BYTE_W-1:0] b);
        return ctrl_t'(b[5:0]);
    endfunction

    function automatic logic [BYTE_W-1:0] ctrl_to_byte(input ctrl_t c);
        return {2'b00, c};
    endfunction
endpackage

// File: rtl/ctim_edge_sync.sv
module ctim_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic bypass,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;
    logic              sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign sel = bypass ? din : chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= sel;
    end

    assign rise = sel & ~prev;
endmodule

// File: rtl/ctim_prescale.sv
module ctim_prescale #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             evt,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CW = (1 << SEL_W) - 1;

    logic [CW-1:0] pcnt;
    logic [CW-1:0] limit;
    logic          at_lim;

    always_comb limit = CW'((1 << sel) - 1);
    assign at_lim = (pcnt >= limit);
    assign tick   = evt && at_lim && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pcnt <= '0;
        end else if (evt) begin
            if (at_lim) pcnt <= '0;
            else        pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/ctim_compare.sv
module ctim_compare
    import ctim_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      cnt,
    input  logic [W-1:0]      cmp,
    input  logic [MODE_W-1:0] mode,
    input  logic              tick,
    input  logic              allow,
    output logic              trig,
    output logic              pulse
);
    assign trig = (mode == MODE_SPECIAL) && (cnt == cmp) && tick && allow;

    always_ff @(posedge clk) begin
        if (rst) pulse <= 1'b0;
        else     pulse <= trig;
    end
endmodule

// File: rtl/cmp_timer16.sv
module cmp_timer16
    import ctim_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_in,
    output logic              irq,
    output logic              adc_start
);
    reg_addr_e         addr;
    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cmp_q;
    logic [MODE_W-1:0] mode_q;
    logic              ovf_flag_q;
    logic              ovf_ie_q;

    logic wr_ctrl, wr_lo, wr_hi, wr_cmp_lo, wr_cmp_hi, wr_mode, wr_flag, wr_ie;
    logic cnt_wr;
    logic ext_rise, count_evt, cnt_tick;
    logic trig_allow, spec_trig, wrap_set, timer_run;

    assign addr      = reg_addr_e'(bus_addr);
    assign wr_ctrl   = bus_we && (addr == A_CTRL);
    assign wr_lo     = bus_we && (addr == A_CNT_LO);
    assign wr_hi     = bus_we && (addr == A_CNT_HI);
    assign wr_cmp_lo = bus_we && (addr == A_CMP_LO);
    assign wr_cmp_hi = bus_we && (addr == A_CMP_HI);
    assign wr_mode   = bus_we && (addr == A_MODE);
    assign wr_flag   = bus_we && (addr == A_FLAG);
    assign wr_ie     = bus_we && (addr == A_IE);
    assign cnt_wr    = wr_lo || wr_hi;
    assign timer_run = ctrl_q.run;

    ctim_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (ext_in),
        .bypass(ctrl_q.async_ext),
        .rise  (ext_rise)
    );

    assign count_evt = ctrl_q.run && (ctrl_q.ext_src ? ext_rise : 1'b1);

    ctim_prescale #(.SEL_W(PS_SEL_W)) u_ps (
        .clk (clk),
        .rst (rst),
        .clr (cnt_wr),
        .evt (count_evt),
        .sel (ctrl_q.prescale),
        .tick(cnt_tick)
    );

    assign trig_allow = !(ctrl_q.ext_src && ctrl_q.async_ext) && !cnt_wr;

    ctim_compare #(.W(CNT_W)) u_cmp (
        .clk  (clk),
        .rst  (rst),
        .cnt  (cnt_q),
        .cmp  (cmp_q),
        .mode (mode_q),
        .tick (cnt_tick),
        .allow(trig_allow),
        .trig (spec_trig),
        .pulse(adc_start)
    );

    // Counter keeps its value through reset.
    always_ff @(posedge clk) begin
        if (wr_lo)          cnt_q <= {cnt_q[CNT_W-1:BYTE_W], bus_wdata};
        else if (wr_hi)     cnt_q <= {bus_wdata, cnt_q[BYTE_W-1:0]};
        else if (spec_trig) cnt_q <= '0;
        else if (cnt_tick)  cnt_q <= cnt_q + 1'b1;
    end

    assign wrap_set = cnt_tick && (cnt_q == {CNT_W{1'b1}}) && !spec_trig && !cnt_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            cmp_q      <= '0;
            mode_q     <= '0;
            ovf_flag_q <= 1'b0;
            ovf_ie_q   <= 1'b0;
        end else begin
            if (wr_ctrl)   ctrl_q <= ctrl_from_byte(bus_wdata);
            if (wr_cmp_lo) cmp_q  <= {cmp_q[CNT_W-1:BYTE_W], bus_wdata};
            if (wr_cmp_hi) cmp_q  <= {bus_wdata, cmp_q[BYTE_W-1:0]};
            if (wr_mode)   mode_q <= bus_wdata[MODE_W-1:0];
            if (wr_ie)     ovf_ie_q <= bus_wdata[0];
            if (wrap_set)     ovf_flag_q <= 1'b1;
            else if (wr_flag) ovf_flag_q <= bus_wdata[0];
        end
    end

    assign irq = ovf_flag_q && ovf_ie_q;

    always_comb begin
        unique case (addr)
            A_CTRL:   bus_rdata = ctrl_to_byte(ctrl_q);
            A_CNT_LO: bus_rdata = cnt_q[BYTE_W-1:0];
            A_CNT_HI: bus_rdata = cnt_q[CNT_W-1:BYTE_W];
            A_CMP_LO: bus_rdata = cmp_q[BYTE_W-1:0];
            A_CMP_HI: bus_rdata = cmp_q[CNT_W-1:BYTE_W];
            A_MODE:   bus_rdata = {{(BYTE_W-MODE_W){1'b0}}, mode_q};
            A_FLAG:   bus_rdata = {{(BYTE_W-1){1'b0}}, ovf_flag_q};
            A_IE:     bus_rdata = {{(BYTE_W-1){1'b0}}, ovf_ie_q};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ctim_checker.sv
module ctim_checker
    import ctim_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [1:0]        rdata_top,
    input logic [CNT_W-1:0]  cnt,
    input logic              flag,
    input logic              trig,
    input logic              run,
    input logic              irq,
    input logic              adc_start
);
    logic w_lo, w_hi, w_flag;
    assign w_lo   = bus_we && (bus_addr == 3'd1);
    assign w_hi   = bus_we && (bus_addr == 3'd2);
    assign w_flag = bus_we && (bus_addr == 3'd6);

    p_cnt_step_r1: assert property (@(posedge clk) disable iff (rst)
        (!w_lo && !w_hi) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 16'd1 || cnt == 16'd0));

    p_flag_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (flag && !w_flag) |=> flag);

    p_irq_needs_flag_r4: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);

    p_trig_clears_r5: assert property (@(posedge clk) disable iff (rst)
        trig |=> (cnt == 16'd0 && adc_start));

    p_trig_noflag_r6: assert property (@(posedge clk) disable iff (rst)
        (trig && !flag && !w_flag) |=> !flag);

    p_write_lo_r7: assert property (@(posedge clk) disable iff (rst)
        w_lo |=> (cnt[7:0] == $past(bus_wdata)));

    p_ctrl_upper_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd0) |-> (rdata_top == 2'b00));

    p_stopped_r11: assert property (@(posedge clk) disable iff (rst)
        (!run && !w_lo && !w_hi) |=> (cnt == $past(cnt)));
endmodule

bind cmp_timer16 ctim_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .rdata_top(bus_rdata[7:6]),
    .cnt      (cnt_q),
    .flag     (ovf_flag_q),
    .trig     (spec_trig),
    .run      (timer_run),
    .irq      (irq),
    .adc_start(adc_start)
);

// File: tb/cmp_timer16_test.sv
module cmp_timer16_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_in = 1'b0;
    logic       irq;
    logic       adc_start;

    int checks = 0;
    int fails = 0;
    int adc_n = 0;
    bit done = 0;

    cmp_timer16 uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in),
        .irq(irq), .adc_start(adc_start)
    );

    always #2 clk = ~clk;

    always @(negedge clk) if (adc_start) adc_n++;

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(3'd1, lo); rd(3'd2, hi);
        @(negedge clk);
        v = {hi, lo};
    endtask

    task automatic set_cnt(input logic [15:0] v);
        wr(3'd1, v[7:0]); wr(3'd2, v[15:8]);
    endtask

    task automatic set_cmp(input logic [15:0] v, input logic [3:0] m);
        wr(3'd3, v[7:0]); wr(3'd4, v[15:8]); wr(3'd5, {4'd0, m});
    endtask

    // n internal count events, then stop
    task automatic run_events(input logic [7:0] c, input int n);
        wr(3'd0, c);
        repeat (n - 1) @(negedge clk);
        wr(3'd0, c & 8'hFE);
    endtask

    task automatic pulses(input int k);
        for (int i = 0; i < k; i++) begin
            ext_in = 1'b1; repeat (3) @(negedge clk);
            ext_in = 1'b0; repeat (3) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        rd(3'd0, b); check("R9 ctrl after reset", b, 8'h00);
        rd(3'd6, b); check("R9 flag after reset", b, 0);
        rd(3'd7, b); check("R9 enable after reset", b, 0);
        rd(3'd5, b); check("R9 mode after reset", b, 0);
        check("R4 irq after reset", irq, 0);
        check("R5 adc_start after reset", adc_start, 0);
        @(negedge clk);
        wr(3'd0, 8'hFE); rd(3'd0, b); check("R9 ctrl upper bits", b, 8'h3E);
        wr(3'd0, 8'h00);
        set_cnt(16'h1234);
        rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
        rd16(v); check("R9 counter kept over reset", v, 16'h1234);

        // R2 prescale sweep, R11 stopped hold
        for (int ps = 0; ps < 4; ps++) begin
            set_cnt(16'h0000);
            run_events({2'b00, 2'(ps), 4'b0001}, 40);
            rd16(v); check("R2 prescale count", v, 40 >> ps);
            repeat (10) @(negedge clk);
            rd16(v); check("R11 stopped counter holds", v, 40 >> ps);
        end

        // R2 prescaler cleared by counter write
        set_cnt(16'h0000);
        wr(3'd0, 8'h31);
        repeat (4) @(negedge clk);
        wr(3'd1, 8'h00);
        repeat (6) @(negedge clk);
        wr(3'd0, 8'h30);
        rd16(v); check("R2 prescaler clear on write", v, 0);

        // R1 wrap, R3 flag
        wr(3'd6, 8'h00);
        set_cnt(16'hFFFD);
        run_events(8'h01, 5);
        rd16(v); check("R1 wrap value", v, 16'h0002);
        rd(3'd6, b); check("R3 flag set on wrap", b, 1);
        run_events(8'h01, 3);
        rd(3'd6, b); check("R3 flag stays set", b, 1);
        wr(3'd6, 8'h00); rd(3'd6, b); check("R3 flag cleared", b, 0);

        // R4 interrupt gating sweep
        for (int f = 0; f < 2; f++) begin
            for (int e = 0; e < 2; e++) begin
                wr(3'd6, 8'(f)); wr(3'd7, 8'(e)); #1;
                check("R4 irq gating", irq, f & e);
                @(negedge clk);
            end
        end
        wr(3'd6, 8'h00); wr(3'd7, 8'h00);

        // R5 mode sweep with period 6
        for (int m = 0; m < 16; m++) begin
            set_cnt(16'h0000);
            set_cmp(16'h0005, 4'(m));
            adc_n = 0;
            run_events(8'h01, 20);
            repeat (2) @(negedge clk);
            rd16(v); check("R5 compare reset by mode", v, (m == 11) ? 2 : 20);
            check("R5 adc_start count", adc_n, (m == 11) ? 3 : 0);
            rd(3'd6, b); check("R6 no flag from compare", b, 0);
        end

        // R5 with prescale 4, period 3
        set_cnt(16'h0000); set_cmp(16'h0002, 4'hB);
        run_events(8'h21, 40);
        rd16(v); check("R5 prescaled period", v, 1);

        // R6 compare at 0xFFFF
        wr(3'd6, 8'h00);
        set_cnt(16'hFFFD); set_cmp(16'hFFFF, 4'hB);
        run_events(8'h01, 5);
        rd16(v); check("R6 compare at top value", v, 2);
        rd(3'd6, b); check("R6 flag stays clear", b, 0);

        // R7 write wins over coincident trigger
        set_cmp(16'h0010, 4'hB); set_cnt(16'h0010);
        adc_n = 0;
        wr(3'd0, 8'h01);
        wr(3'd1, 8'h40);
        wr(3'd0, 8'h00);
        repeat (2) @(negedge clk);
        rd16(v); check("R7 write beats reset", v, 16'h0041);
        check("R7 no adc_start", adc_n, 0);

        // R8 external counting
        set_cmp(16'h0000, 4'h0);
        set_cnt(16'h0000); wr(3'd0, 8'h03); pulses(7); wr(3'd0, 8'h02);
        rd16(v); check("R8 synced external edges", v, 7);
        set_cnt(16'h0000); wr(3'd0, 8'h13); pulses(6); wr(3'd0, 8'h12);
        rd16(v); check("R8 synced external prescaled", v, 3);
        set_cnt(16'h0000); wr(3'd0, 8'h07); pulses(9); wr(3'd0, 8'h06);
        rd16(v); check("R8 direct external edges", v, 9);

        // R10 direct mode skips trigger; synced mode does not
        set_cmp(16'h0002, 4'hB);
        set_cnt(16'h0000); adc_n = 0;
        wr(3'd0, 8'h07); pulses(5); wr(3'd0, 8'h06);
        rd16(v); check("R10 direct mode no reset", v, 5);
        check("R10 direct mode no adc_start", adc_n, 0);
        set_cnt(16'h0000); adc_n = 0;
        wr(3'd0, 8'h03); pulses(5); wr(3'd0, 8'h02);
        rd16(v); check("R10 synced mode resets", v, 2);
        check("R10 synced mode adc_start", adc_n, 1);

        summary();
    end
endmodule